// File: doc/BRIEF.md
# Matrix Keypad Scanner with Hold-Lockout

This block reads a 4x4 key matrix. It pulls one row line low at a time. It samples the four column lines through a two-flop synchroniser, so a pressed key in the active row shows as a low column. A small state machine steps through the rows while the matrix is idle. It waits a few settling cycles after each row change and before it samples.

When a key is found, the machine emits its 4-bit hex code for a single cycle. It then waits one more cycle and parks on that row in a hold state. No scanning takes place until the key is released. Any other key pressed during the hold therefore has no effect.

A release counts only when the held column reads high for a run of consecutive synchronised cycles. Scanning then restarts at the following row. Each accepted key also shifts a two-digit history: the new code goes into the right digit, and the previous right digit moves to the left digit.

Top module: `keypad_scanner`

## Requirements
- R1: `row_o` always has exactly one bit low (active row). After reset, bit 0 is the low one (`4'b1110`).
- R2: With no key pressed, the active row advances 0,1,2,3,0,... Each row stays driven for SETTLE_CYCLES+1 cycles, so the synchronised columns reflect that row before they are sampled.
- R3: A key is the active row paired with a low column. Its code, listed for rows 0..3 and columns 0..3, is: row 0: 1 2 3 A; row 1: 4 5 6 B; row 2: 7 8 9 C; row 3: E 0 F D.
- R4: When several columns read low in one sample, the lowest-numbered low column gives the key.
- R5: Every accepted key raises `key_valid_o` for exactly one cycle, with the code on `key_code_o`. A held key produces no further pulses.
- R6: From detection until release, the detected row stays driven and no scanning happens. Keys pressed in that period cause no pulse and no digit update.
- R7: On the cycle after a pulse, `digit_right_o` equals the pulsed code and `digit_left_o` equals the previous `digit_right_o`.
- R8: The hold ends only after the held column reads high for DEBOUNCE consecutive synchronised cycles (default 4). Shorter high bursts keep the row held and trigger nothing.
- R9: After a release, the active row moves to the row following the held one (row 3 wraps to row 0).
- R10: After reset both digits are 0 and `key_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_i | input | 4 | Column lines from the matrix, idle high |
| row_o | output | 4 | Row drive, active row low |
| key_valid_o | output | 1 | One-cycle pulse per accepted key |
| key_code_o | output | 4 | Hex code of the accepted key |
| digit_right_o | output | 4 | Most recent key code |
| digit_left_o | output | 4 | Key code before the most recent one |

## Verification
The bench models the matrix as switches between row and column lines. It presses keys in every row, including two keys in one row at once; a design that picked the highest column would report the wrong code. It presses a second key while the first is held and expects no extra pulse and a stable row; a design that kept scanning would report the second key. It bounces the release with short high bursts, and afterwards expects the next row rather than a repeat; a design with a weak release filter would move the row early or repeat the key.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int unsigned ROWS   = 4;
  localparam int unsigned COLS   = 4;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [2:0] {
    ST_SCAN, ST_SETTLE, ST_DECODE, ST_POST, ST_HOLD
  } kp_state_e;

  function automatic logic [CODE_W-1:0] key_code(input logic [1:0] r, input logic [1:0] c);
    logic [CODE_W-1:0] v;
    case ({r, c})
      4'h0: v = 4'h1; 4'h1: v = 4'h2; 4'h2: v = 4'h3; 4'h3: v = 4'hA;
      4'h4: v = 4'h4; 4'h5: v = 4'h5; 4'h6: v = 4'h6; 4'h7: v = 4'hB;
      4'h8: v = 4'h7; 4'h9: v = 4'h8; 4'hA: v = 4'h9; 4'hB: v = 4'hC;
      4'hC: v = 4'hE; 4'hD: v = 4'h0; 4'hE: v = 4'hF; default: v = 4'hD;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/kp_col_sync.sv
module kp_col_sync #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  // reset to idle-high so no phantom press after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/kp_scan_fsm.sv
module kp_scan_fsm
  import kp_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 2,
  parameter int unsigned DEBOUNCE      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [COLS-1:0]   col_s_i,
  output logic [ROWS-1:0]   row_o,
  output logic              valid_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned CNT_MAX = (SETTLE_CYCLES > DEBOUNCE) ? SETTLE_CYCLES : DEBOUNCE;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] DEB_LAST    = CNT_W'(DEBOUNCE - 1);

  kp_state_e         state_q, state_d;
  logic [1:0]        row_q, row_d, col_q, col_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              hit;
  logic [1:0]        hit_col;

  // lowest-numbered low column wins
  always_comb begin
    hit     = 1'b0;
    hit_col = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (!col_s_i[c]) begin
        hit     = 1'b1;
        hit_col = 2'(c);
      end
    end
  end

  always_comb begin
    state_d = state_q;
    row_d   = row_q;
    col_d   = col_q;
    cnt_d   = cnt_q;
    code_d  = code_q;
    unique case (state_q)
      ST_SCAN: begin
        cnt_d = '0;
        if (hit) begin
          state_d = ST_DECODE;
          col_d   = hit_col;
          code_d  = key_code(row_q, hit_col);
        end else begin
          state_d = ST_SETTLE;
          row_d   = row_q + 2'd1;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          state_d = ST_SCAN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DECODE: state_d = ST_POST;
      ST_POST: begin
        state_d = ST_HOLD;
        cnt_d   = '0;
      end
      ST_HOLD: begin
        if (!col_s_i[col_q]) begin
          cnt_d = '0;
        end else if (cnt_q == DEB_LAST) begin
          state_d = ST_SETTLE;
          row_d   = row_q + 2'd1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SCAN;
      row_q   <= '0;
      col_q   <= '0;
      cnt_q   <= '0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      row_q   <= row_d;
      col_q   <= col_d;
      cnt_q   <= cnt_d;
      code_q  <= code_d;
    end
  end

  assign row_o   = ~(ROWS'(1) << row_q);
  assign valid_o = (state_q == ST_DECODE);
  assign code_o  = code_q;

  // R1
  row_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~row_o) == 1);
  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  hold_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && state_d == ST_HOLD) |=> $stable(row_o));
  // R8
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && !col_s_i[col_q]) |=> (state_q == ST_HOLD));
endmodule

// File: rtl/kp_digit_hist.sv
module kp_digit_hist
  import kp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] right_o,
  output logic [CODE_W-1:0] left_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      right_o <= '0;
      left_o  <= '0;
    end else if (valid_i) begin
      right_o <= code_i;
      left_o  <= right_o;
    end
  end

  // R7
  hist_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (right_o == $past(code_i) && left_o == $past(right_o)));
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import kp_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 2,
  parameter int unsigned DEBOUNCE      = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  col_i,
  output logic [3:0]  row_o,
  output logic        key_valid_o,
  output logic [3:0]  key_code_o,
  output logic [3:0]  digit_right_o,
  output logic [3:0]  digit_left_o
);
  logic [COLS-1:0] col_s;

  kp_col_sync #(.WIDTH(COLS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (col_i),
    .q_o   (col_s)
  );

  kp_scan_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES), .DEBOUNCE(DEBOUNCE)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .col_s_i(col_s),
    .row_o  (row_o),
    .valid_o(key_valid_o),
    .code_o (key_code_o)
  );

  kp_digit_hist u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(key_valid_o),
    .code_i (key_code_o),
    .right_o(digit_right_o),
    .left_o (digit_left_o)
  );
endmodule

// File: tb/tb_keypad_scanner.sv
module tb_keypad_scanner;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] col_i, row_o, key_code_o, digit_right_o, digit_left_o;
  logic       key_valid_o;
  logic [3:0] keys [4];   // keys[row][col] closed switches

  int   checks = 0, fails = 0;
  bit   done = 0;
  logic [3:0] exp_q [$];

  keypad_scanner dut (.*);

  always #4 clk_i = ~clk_i;

  always_comb begin
    for (int c = 0; c < 4; c++) begin
      col_i[c] = 1'b1;
      for (int r = 0; r < 4; r++)
        if (keys[r][c] && !row_o[r]) col_i[c] = 1'b0;
    end
  end

  function automatic logic [3:0] ref_code(int r, int c);
    logic [3:0] tbl [16] = '{4'h1,4'h2,4'h3,4'hA, 4'h4,4'h5,4'h6,4'hB,
                             4'h7,4'h8,4'h9,4'hC, 4'hE,4'h0,4'hF,4'hD};
    return tbl[r*4 + c];
  endfunction

  function automatic logic [3:0] row_pat(int r);
    return ~(4'b1 << r);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected codes as pulses arrive
  initial begin
    logic [3:0] prev = 4'h0;
    forever begin
      @(negedge clk_i);
      if (rst_ni && key_valid_o) begin
        logic [3:0] e;
        if (exp_q.size() == 0) begin
          chk(0, "R6", "unexpected key pulse", key_code_o, 0);
          e = key_code_o;
        end else begin
          e = exp_q.pop_front();
          chk(key_code_o == e, "R3", "key code", key_code_o, e);
        end
        @(negedge clk_i);
        chk(!key_valid_o, "R5", "pulse width", key_valid_o, 0);
        chk(digit_right_o == e, "R7", "right digit", digit_right_o, e);
        chk(digit_left_o == prev, "R7", "left digit", digit_left_o, prev);
        prev = e;
      end
    end
  end

  task automatic release_key(int r);
    logic [3:0] saved = keys[r];
    bit held = 1;
    for (int b = 0; b < 3; b++) begin
      keys[r] = '0;
      repeat (2) begin @(negedge clk_i); held &= (row_o == row_pat(r)); end
      keys[r] = saved;
      repeat (2) begin @(negedge clk_i); held &= (row_o == row_pat(r)); end
    end
    chk(held, "R8", "row held through bounce", row_o, row_pat(r));
    keys[r] = '0;
    for (int i = 0; i < 40 && row_o == row_pat(r); i++) @(negedge clk_i);
    chk(row_o == row_pat((r + 1) % 4), "R9", "row after release", row_o, row_pat((r + 1) % 4));
    repeat (20) @(negedge clk_i);
  endtask

  // driver: closes switches and pushes the expected code
  task automatic press(int r, int c, int c2 = -1);
    keys[r][c] = 1'b1;
    if (c2 >= 0) keys[r][c2] = 1'b1;
    exp_q.push_back(ref_code(r, (c2 >= 0 && c2 < c) ? c2 : c));
    repeat (40) @(negedge clk_i);
    release_key(r);
  endtask

  initial begin
    for (int r = 0; r < 4; r++) keys[r] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(row_o == 4'b1110, "R1", "reset row", row_o, 4'b1110);
    chk(digit_right_o == 0 && digit_left_o == 0, "R10", "reset digits",
        {digit_left_o, digit_right_o}, 0);
    chk(!key_valid_o, "R10", "reset valid", key_valid_o, 0);

    // R2: idle rotation order
    begin
      logic [3:0] last = row_o;
      int steps = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk_i);
        if (row_o != last) begin
          chk(row_o == {last[2:0], last[3]}, "R2", "scan order", row_o, {last[2:0], last[3]});
          last = row_o;
          steps++;
        end
      end
      chk(steps >= 5, "R2", "row steps seen", steps, 5);
    end

    press(0, 0);
    press(1, 1);
    press(2, 3);
    press(3, 1);
    press(3, 0);
    press(0, 3);
    // R4: two columns low in one row
    press(1, 2, 0);

    // R6: second key during hold
    keys[0][0] = 1'b1;
    exp_q.push_back(ref_code(0, 0));
    repeat (40) @(negedge clk_i);
    keys[2][3] = 1'b1;
    begin
      bit stable = 1;
      repeat (20) begin @(negedge clk_i); stable &= (row_o == 4'b1110); end
      chk(stable, "R6", "row during hold", row_o, 4'b1110);
    end
    keys[2][3] = 1'b0;
    repeat (4) @(negedge clk_i);
    release_key(0);

    repeat (20) @(negedge clk_i);
    chk(exp_q.size() == 0, "R5", "pending expected keys", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule